// File: doc/BRIEF.md
# Deep-Sleep Power Rail Controller

This block sits inside a system I/O controller and turns the platform controller's sleep handshake into two active-low power-switch enables. The first enable gates the standby rails and the second gates the always-on rails. A low level on either enable turns its rail on through a P-channel switch. Both enables are driven high, turning the rails off, while the suspend-sleep input is asserted (low). They return low as soon as that input is released.

A 2-bit mode field selects one of two behaviours. In plain deep-sleep mode, both enables track the sleep input. In the extended mode, the standby enable still tracks the sleep input. The always-on enable turns its rail off only after deep sleep has been held for a programmable number of slow ticks. A prescaler produces those ticks; with a 100 ms tick, a count of 64 gives the usual 6.4 s. The block also answers the suspend warning with a suspend acknowledge, and it drives a deep-sleep power-good output.

All asynchronous inputs pass through two-flop synchronizers. Every output is registered, so any input change reaches the outputs on the third rising clock edge after it is applied.

Top module: `dsw_rail_ctrl`

## Requirements
- R1: While reset is held, both rail enables are low (rails on), the acknowledge output is high (deasserted) and the power-good output is low.
- R2: The standby enable equals the inverse of the suspend-sleep input, delayed by exactly three rising clock edges.
- R3: In plain mode (mode 2'b00) and for the unused encodings 2'b10 and 2'b11, the always-on enable equals the standby enable.
- R4: In extended mode (mode 2'b01) with a delay count N greater than 0, the always-on enable goes high exactly N*TICK_DIV clock edges after the standby enable goes high, and it never goes high while the standby enable is low.
- R5: Releasing the sleep input while the delay is pending cancels it. Both enables go low on the third edge after the release, and the next sleep entry counts the full delay again from zero.
- R6: In extended mode with a delay count of 0, the always-on enable goes high on the same edge as the standby enable.
- R7: The acknowledge output (active low) equals the suspend-warning input (active low), delayed by exactly three rising clock edges.
- R8: The power-good output goes high on the first rising edge after reset is released and stays high.
- R9: If the mode leaves extended mode while the block is asleep, the always-on enable goes high on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_sus_n | input | 1 | Suspend-sleep from the platform controller, active low, asynchronous |
| sus_warn_n | input | 1 | Suspend warning, active low, asynchronous |
| mode | input | 2 | Control mode: 00 plain, 01 extended, 10/11 treated as plain |
| dly_ticks | input | DLY_W | Extended-entry delay in prescaler ticks |
| sus_ack_n | output | 1 | Suspend acknowledge, active low |
| dsw_pwrok | output | 1 | Deep-sleep well power-good |
| rail_sb_en_n | output | 1 | Standby rail switch enable, active low |
| rail_aon_en_n | output | 1 | Always-on rail switch enable, active low |

## Verification
The assertions assume that mode and dly_ticks are quasi-static configuration values that change only on a clock edge. They also assume that the asynchronous inputs never change closer to an edge than the synchronizer can absorb, so each input change is seen by the first flop on a known edge. The bench keeps to these assumptions: it changes every input on the falling clock edge and counts rising edges from that change before it samples any output. The only mid-sleep configuration change it makes is the single mode switch that R9 covers.

// File: rtl/dsw_rail_pkg.sv
package dsw_rail_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'b00,
        MODE_EXT    = 2'b01,
        MODE_RSVD_A = 2'b10,
        MODE_RSVD_B = 2'b11
    } dsw_mode_e;

    typedef struct packed {
        logic sb_off;
        logic aon_off;
    } rail_cmd_t;

    localparam rail_cmd_t RAILS_ON = '{sb_off: 1'b0, aon_off: 1'b0};

    function automatic logic is_ext(input logic [1:0] m);
        return m == MODE_EXT;
    endfunction

    function automatic rail_cmd_t rail_decide(input logic asleep,
                                              input logic ext,
                                              input logic expired);
        rail_cmd_t c;
        c.sb_off  = asleep;
        c.aon_off = asleep && (!ext || expired);
        return c;
    endfunction

endpackage

// File: rtl/dsw_sync.sv
module dsw_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dsw_tick_gen.sv
module dsw_tick_gen #(
    parameter int DIV = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pre;

    assign tick = run && (pre == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre <= '0;
        end else if (tick) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/dsw_entry_timer.sv
module dsw_entry_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [DLY_W-1:0] limit,
    output logic             expired
);
    logic [DLY_W-1:0] cnt;

    assign expired = run && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dsw_rail_ctrl.sv
module dsw_rail_ctrl
    import dsw_rail_pkg::*;
#(
    parameter int TICK_DIV = 12_500_000,
    parameter int DLY_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slp_sus_n,
    input  logic             sus_warn_n,
    input  logic [1:0]       mode,
    input  logic [DLY_W-1:0] dly_ticks,
    output logic             sus_ack_n,
    output logic             dsw_pwrok,
    output logic             rail_sb_en_n,
    output logic             rail_aon_en_n
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_in, syn_in;
    logic             asleep, warn_n_s, tick, expired;
    rail_cmd_t        cmd, cmd_q;

    assign raw_in = {sus_warn_n, slp_sus_n};

    dsw_sync #(.W(NSYNC), .RST_VAL({NSYNC{1'b1}})) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign asleep   = !syn_in[0];
    assign warn_n_s = syn_in[1];

    dsw_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (asleep),
        .tick (tick)
    );

    dsw_entry_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (asleep),
        .tick    (tick),
        .limit   (dly_ticks),
        .expired (expired)
    );

    assign cmd = rail_decide(asleep, is_ext(mode), expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= RAILS_ON;
            sus_ack_n <= 1'b1;
            dsw_pwrok <= 1'b0;
        end else begin
            cmd_q     <= cmd;
            sus_ack_n <= warn_n_s;
            dsw_pwrok <= 1'b1;
        end
    end

    assign rail_sb_en_n  = cmd_q.sb_off;
    assign rail_aon_en_n = cmd_q.aon_off;
endmodule

// File: rtl/dsw_rail_ctrl_chk.sv
module dsw_rail_ctrl_chk #(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             slp_sus_n,
    input logic             sus_warn_n,
    input logic [1:0]       mode,
    input logic [DLY_W-1:0] dly_ticks,
    input logic             sus_ack_n,
    input logic             dsw_pwrok,
    input logic             rail_sb_en_n,
    input logic             rail_aon_en_n
);
    logic [1:0] age;
    logic       age_ok;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign age_ok = (age == 2'd3);

    p_sb_follow_r2: assert property (@(posedge clk) disable iff (rst)
        age_ok |-> (rail_sb_en_n == !$past(slp_sus_n, 3)));

    p_plain_aon_r3: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(mode) != 2'b01) |-> (rail_aon_en_n == rail_sb_en_n));

    p_aon_after_sb_r4: assert property (@(posedge clk) disable iff (rst)
        rail_aon_en_n |-> rail_sb_en_n);

    p_ext_late_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(rail_aon_en_n) && $past(mode) == 2'b01 && $past(dly_ticks) != '0)
            |-> $past(rail_sb_en_n));

    p_wake_both_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rail_sb_en_n) |-> !rail_aon_en_n);

    p_ack_follow_r7: assert property (@(posedge clk) disable iff (rst)
        age_ok |-> (sus_ack_n == $past(sus_warn_n, 3)));

    p_pwrok_r8: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0) |-> dsw_pwrok);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!rail_sb_en_n && !rail_aon_en_n && sus_ack_n && !dsw_pwrok));
endmodule

bind dsw_rail_ctrl dsw_rail_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .slp_sus_n     (slp_sus_n),
    .sus_warn_n    (sus_warn_n),
    .mode          (mode),
    .dly_ticks     (dly_ticks),
    .sus_ack_n     (sus_ack_n),
    .dsw_pwrok     (dsw_pwrok),
    .rail_sb_en_n  (rail_sb_en_n),
    .rail_aon_en_n (rail_aon_en_n)
);

// File: tb/dsw_rail_ctrl_tb.sv
module dsw_rail_ctrl_tb;
    localparam int DIV   = 4;
    localparam int DLY_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             slp_sus_n = 1'b1;
    logic             sus_warn_n = 1'b1;
    logic [1:0]       mode = 2'b00;
    logic [DLY_W-1:0] dly_ticks = 8'd3;
    logic             sus_ack_n, dsw_pwrok, rail_sb_en_n, rail_aon_en_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dsw_rail_ctrl #(.TICK_DIV(DIV), .DLY_W(DLY_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .slp_sus_n     (slp_sus_n),
        .sus_warn_n    (sus_warn_n),
        .mode          (mode),
        .dly_ticks     (dly_ticks),
        .sus_ack_n     (sus_ack_n),
        .dsw_pwrok     (dsw_pwrok),
        .rail_sb_en_n  (rail_sb_en_n),
        .rail_aon_en_n (rail_aon_en_n)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic t_reset;
        edges(2);
        chk("R1 sb", rail_sb_en_n, 1'b0);
        chk("R1 aon", rail_aon_en_n, 1'b0);
        chk("R1 ack", sus_ack_n, 1'b1);
        chk("R1 pwrok", dsw_pwrok, 1'b0);
        rst = 1'b0;
        edges(1);
        chk("R8 pwrok", dsw_pwrok, 1'b1);
        edges(3);
    endtask

    task automatic t_plain;
        mode = 2'b00;
        slp_sus_n = 1'b0;
        edges(2);
        chk("R2 sb before", rail_sb_en_n, 1'b0);
        edges(1);
        chk("R2 sb off", rail_sb_en_n, 1'b1);
        chk("R3 aon off", rail_aon_en_n, 1'b1);
        slp_sus_n = 1'b1;
        edges(3);
        chk("R2 sb on", rail_sb_en_n, 1'b0);
        chk("R3 aon on", rail_aon_en_n, 1'b0);
        chk("R8 pwrok held", dsw_pwrok, 1'b1);
    endtask

    task automatic t_ext_delay;
        mode = 2'b01; dly_ticks = 8'd3;
        slp_sus_n = 1'b0;
        edges(3);
        chk("R4 sb off", rail_sb_en_n, 1'b1);
        chk("R4 aon held", rail_aon_en_n, 1'b0);
        edges(11);
        chk("R4 aon before", rail_aon_en_n, 1'b0);
        edges(1);
        chk("R4 aon off", rail_aon_en_n, 1'b1);
        slp_sus_n = 1'b1;
        edges(3);
        chk("R5 sb wake", rail_sb_en_n, 1'b0);
        chk("R5 aon wake", rail_aon_en_n, 1'b0);
    endtask

    task automatic t_cancel;
        mode = 2'b01; dly_ticks = 8'd3;
        slp_sus_n = 1'b0;
        edges(10);
        slp_sus_n = 1'b1;
        edges(3);
        chk("R5 cancel sb", rail_sb_en_n, 1'b0);
        chk("R5 cancel aon", rail_aon_en_n, 1'b0);
        slp_sus_n = 1'b0;
        edges(14);
        chk("R5 restart before", rail_aon_en_n, 1'b0);
        edges(1);
        chk("R5 restart off", rail_aon_en_n, 1'b1);
        slp_sus_n = 1'b1;
        edges(3);
    endtask

    task automatic t_zero;
        mode = 2'b01; dly_ticks = 8'd0;
        slp_sus_n = 1'b0;
        edges(2);
        chk("R6 aon before", rail_aon_en_n, 1'b0);
        edges(1);
        chk("R6 aon with sb", rail_aon_en_n, 1'b1);
        chk("R6 sb", rail_sb_en_n, 1'b1);
        slp_sus_n = 1'b1;
        edges(3);
        dly_ticks = 8'd3;
    endtask

    task automatic t_unused;
        for (int m = 2; m < 4; m++) begin
            mode = 2'(m);
            slp_sus_n = 1'b0;
            edges(3);
            chk("R3 unused aon", rail_aon_en_n, 1'b1);
            slp_sus_n = 1'b1;
            edges(3);
            chk("R3 unused wake", rail_aon_en_n, 1'b0);
        end
    endtask

    task automatic t_mode_switch;
        mode = 2'b01; dly_ticks = 8'd3;
        slp_sus_n = 1'b0;
        edges(5);
        chk("R9 aon pending", rail_aon_en_n, 1'b0);
        mode = 2'b00;
        edges(1);
        chk("R9 aon off", rail_aon_en_n, 1'b1);
        slp_sus_n = 1'b1;
        edges(3);
    endtask

    task automatic t_ack;
        sus_warn_n = 1'b0;
        edges(2);
        chk("R7 ack before", sus_ack_n, 1'b1);
        edges(1);
        chk("R7 ack on", sus_ack_n, 1'b0);
        sus_warn_n = 1'b1;
        edges(2);
        chk("R7 ack hold", sus_ack_n, 1'b0);
        edges(1);
        chk("R7 ack off", sus_ack_n, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_plain;
        t_ext_delay;
        t_cancel;
        t_zero;
        t_unused;
        t_mode_switch;
        t_ack;
        done = 1'b1;
        summary;
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1..: actual=running expected=finished");
            summary;
            $finish;
        end
    end
endmodule